// File: doc/BRIEF.md
# Segment Register Load Checker

This unit guards every write of a selector into one of the six segment registers of a protected-mode core. The core presents one request at a time. A request carries the target register, the 16-bit selector, the current descriptor table limit and the type, S and P fields of the descriptor that was fetched for that selector. The unit runs a fixed chain of checks and reports one of three results: commit, general-protection fault or not-present fault. Each fault comes with its exception vector.

On a commit the unit writes the selector into the visible register. It also copies the descriptor attributes into that register's hidden cache entry, with the accessed bit forced to one. On any fault both the visible selector and the hidden entry keep their old contents.

A read port lets the rest of the core look at any register's current selector and cache entry. Privilege comparison, local-table lookup and task switching happen elsewhere.

Top module: `seg_load_check`

## Requirements
- R1: A selector whose index field (bits 15:3) is zero is null. A null selector loaded into CS (code 0) or SS (code 1) gives a general-protection fault, vector 13. TI and RPL bits do not matter.
- R2: A null selector loaded into DS (2), ES (3), FS (4) or GS (5) commits. The selector is stored, and the cache entry is marked unusable with type, S and P all zero.
- R3: A non-null selector passes the bounds test only if index*8+7 is less than or equal to the table limit. Otherwise the result is a general-protection fault, vector 13.
- R4: A descriptor with S=0 is rejected for every register with vector 13. CS accepts only code descriptors (type bit 3 set).
- R5: SS accepts only data descriptors (type bit 3 clear) with the writable bit (type bit 1) set. A code descriptor is never accepted into SS.
- R6: DS, ES, FS and GS accept data descriptors, and code descriptors whose readable bit (type bit 1) is set. Execute-only code gives vector 13.
- R7: A descriptor with P=0 that passes every other check gives a not-present fault. The vector is 12 when the target is SS and 11 otherwise.
- R8: The checks run in this order: null, bounds, type, present. The first one that fails decides the result and the vector.
- R9: After any fault, the target register's selector and cache entry are unchanged.
- R10: A non-null commit stores the selector, the type with bit 0 (accessed) forced to one, S, P and usable=1.
- R11: A request is taken on a clock edge where req_valid is high and busy is low. busy is high for the next cycle only, and done pulses for exactly one cycle after it. Requests presented while busy is high are ignored.
- R12: After reset, busy and done are low and every register reads selector 0 with usable, type, S and P all zero. outcome encodes 0 for commit, 1 for general-protection fault and 2 for not-present fault. vector reads 0 on a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request strobe |
| req_seg | input | 3 | Target register code (0 CS, 1 SS, 2 DS, 3 ES, 4 FS, 5 GS) |
| req_sel | input | 16 | Selector to load |
| req_limit | input | 16 | Descriptor table limit |
| req_type | input | 4 | Fetched descriptor type field |
| req_s | input | 1 | Fetched descriptor S bit (1 = code/data) |
| req_p | input | 1 | Fetched descriptor present bit |
| busy | output | 1 | Request in progress; new requests ignored |
| done | output | 1 | One-cycle result strobe |
| outcome | output | 2 | 0 commit, 1 general-protection fault, 2 not-present fault |
| vector | output | 8 | Exception vector for the result, 0 on commit |
| rd_seg | input | 3 | Register code to inspect |
| rd_sel | output | 16 | Visible selector of the inspected register |
| rd_type | output | 4 | Cached type of the inspected register |
| rd_s | output | 1 | Cached S bit |
| rd_p | output | 1 | Cached present bit |
| rd_usable | output | 1 | Cache entry holds a usable descriptor |

## Verification
Loads are tried in several patterns. Good descriptors into each register class check that the per-register type rules tell code, read-only data, writable data and execute-only code apart. Null selectors go into both the code/stack pair and the data registers, which separates the fault path from the unusable-commit path. Limits set exactly at and one below index*8+7 pin down the bounds edge. Descriptors with two faults at once confirm that the earlier check wins. After every load the bench reads the target register back, so a fault that quietly changed state shows up. The accessed bit is checked both when it arrives clear and when it arrives already set.

// File: rtl/seg_pkg.sv
// Shared register codes, result codes, vectors and the cache entry layout
// for the segment register load checker.
package seg_pkg;

    // Target register codes as seen on req_seg / rd_seg.
    typedef enum logic [2:0] {
        SEG_CS = 3'd0,
        SEG_SS = 3'd1,
        SEG_DS = 3'd2,
        SEG_ES = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_id_e;

    // Result codes as seen on outcome.
    typedef enum logic [1:0] {
        RES_OK = 2'd0,
        RES_GP = 2'd1,
        RES_NP = 2'd2
    } res_e;

    localparam logic [7:0] VEC_NONE  = 8'd0;
    localparam logic [7:0] VEC_GP    = 8'd13;
    localparam logic [7:0] VEC_SS_NP = 8'd12;
    localparam logic [7:0] VEC_NP    = 8'd11;

    // Descriptor type bit positions.
    localparam int TYP_ACC  = 0;
    localparam int TYP_RW   = 1;
    localparam int TYP_CODE = 3;

endpackage

// File: rtl/seg_load_eval.sv
// Combinational check chain for one segment register load.
// Assumes the descriptor fields belong to the selector's table slot and that
// only the global table is in use. Checks run null, bounds, type, present;
// the first failure decides outcome and vector.
module seg_load_eval
    import seg_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int LIM_W = 16
) (
    input  logic [2:0]       seg,
    input  logic [SEL_W-1:0] sel,
    input  logic [LIM_W-1:0] limit,
    input  logic [3:0]       typ,
    input  logic             s_bit,
    input  logic             p_bit,
    output res_e             res,
    output logic [7:0]       vec,
    output logic             usable
);

    localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

    logic             is_cs;
    logic             is_ss;
    logic             is_data_reg;
    logic             is_null;
    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] lim_ext;
    logic             bounds_ok;
    logic             type_ok;

    // Decode the target and evaluate each individual test.
    always_comb begin
        is_cs       = (seg == SEG_CS);
        is_ss       = (seg == SEG_SS);
        is_data_reg = (seg == SEG_DS) || (seg == SEG_ES) ||
                      (seg == SEG_FS) || (seg == SEG_GS);
        is_null     = (sel[SEL_W-1:3] == '0);
        last_byte   = CMP_W'({sel[SEL_W-1:3], 3'b111});
        lim_ext     = CMP_W'(limit);
        bounds_ok   = (last_byte <= lim_ext);
        if (!s_bit)
            type_ok = 1'b0;
        else if (is_cs)
            type_ok = typ[TYP_CODE];
        else if (is_ss)
            type_ok = !typ[TYP_CODE] && typ[TYP_RW];
        else if (is_data_reg)
            type_ok = !typ[TYP_CODE] || typ[TYP_RW];
        else
            type_ok = 1'b0;
    end

    // Apply the priority chain and pick the first failing test.
    always_comb begin
        res    = RES_OK;
        vec    = VEC_NONE;
        usable = 1'b1;
        if (is_null) begin
            if (is_data_reg) begin
                usable = 1'b0;
            end else begin
                res = RES_GP;
                vec = VEC_GP;
            end
        end else if (!bounds_ok) begin
            res = RES_GP;
            vec = VEC_GP;
        end else if (!type_ok) begin
            res = RES_GP;
            vec = VEC_GP;
        end else if (!p_bit) begin
            res = RES_NP;
            vec = is_ss ? VEC_SS_NP : VEC_NP;
        end
    end

endmodule

// File: rtl/seg_file.sv
// Visible selectors and hidden cache entries for the segment registers.
// One entry per register, written only on a committed load. A usable write
// forces the accessed bit; an unusable write clears the attributes.
module seg_file #(
    parameter int NUM_SEG = 6,
    parameter int SEL_W   = 16,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [3:0]       wr_typ,
    input  logic             wr_s,
    input  logic             wr_p,
    input  logic             wr_usable,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SEL_W-1:0] rd_sel,
    output logic [3:0]       rd_typ,
    output logic             rd_s,
    output logic             rd_p,
    output logic             rd_usable
);

    logic [NUM_SEG-1:0][SEL_W-1:0] sel_q;
    logic [NUM_SEG-1:0][3:0]       typ_q;
    logic [NUM_SEG-1:0]            s_q;
    logic [NUM_SEG-1:0]            p_q;
    logic [NUM_SEG-1:0]            use_q;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
        // Hold or replace one register's selector and cache entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[g] <= '0;
                typ_q[g] <= '0;
                s_q[g]   <= 1'b0;
                p_q[g]   <= 1'b0;
                use_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                sel_q[g] <= wr_sel;
                typ_q[g] <= wr_usable ? (wr_typ | 4'b0001) : 4'b0000;
                s_q[g]   <= wr_usable && wr_s;
                p_q[g]   <= wr_usable && wr_p;
                use_q[g] <= wr_usable;
            end
        end
    end

    // Read mux; codes beyond the register count read as zero.
    always_comb begin
        if (rd_idx < IDX_W'(NUM_SEG)) begin
            rd_sel    = sel_q[rd_idx];
            rd_typ    = typ_q[rd_idx];
            rd_s      = s_q[rd_idx];
            rd_p      = p_q[rd_idx];
            rd_usable = use_q[rd_idx];
        end else begin
            rd_sel    = '0;
            rd_typ    = '0;
            rd_s      = 1'b0;
            rd_p      = 1'b0;
            rd_usable = 1'b0;
        end
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> ($stable(sel_q) && $stable(typ_q) && $stable(use_q))); // R9
    AST_ACCESSED_SET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_usable && (wr_idx < IDX_W'(NUM_SEG))) |=> typ_q[$past(wr_idx)][0]); // R10

endmodule

// File: rtl/seg_load_check.sv
// Segment register load checker top. Captures one request while idle,
// evaluates it in the following cycle, pulses done with the result and,
// on commit only, updates the addressed register. Descriptor fields arrive
// with the request; no privilege or local-table handling.
module seg_load_check
    import seg_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEL_W   = 16,
    parameter int LIM_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_seg,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [LIM_W-1:0] req_limit,
    input  logic [3:0]       req_type,
    input  logic             req_s,
    input  logic             req_p,
    output logic             busy,
    output logic             done,
    output logic [1:0]       outcome,
    output logic [7:0]       vector,
    input  logic [2:0]       rd_seg,
    output logic [SEL_W-1:0] rd_sel,
    output logic [3:0]       rd_type,
    output logic             rd_s,
    output logic             rd_p,
    output logic             rd_usable
);

    localparam int IDX_W = 3;

    logic             busy_q;
    logic             done_q;
    res_e             res_q;
    logic [7:0]       vec_q;
    logic [2:0]       cur_seg;
    logic [SEL_W-1:0] cur_sel;
    logic [LIM_W-1:0] cur_limit;
    logic [3:0]       cur_typ;
    logic             cur_s;
    logic             cur_p;
    res_e             eval_res;
    logic [7:0]       eval_vec;
    logic             eval_usable;
    logic             commit;
    logic             accept;

    assign accept = req_valid && !busy_q;
    assign commit = busy_q && (eval_res == RES_OK);

    // Capture the request fields when a new load is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_seg   <= '0;
            cur_sel   <= '0;
            cur_limit <= '0;
            cur_typ   <= '0;
            cur_s     <= 1'b0;
            cur_p     <= 1'b0;
        end else if (accept) begin
            cur_seg   <= req_seg;
            cur_sel   <= req_sel;
            cur_limit <= req_limit;
            cur_typ   <= req_type;
            cur_s     <= req_s;
            cur_p     <= req_p;
        end
    end

    // Two-phase control: accept, then report and return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            res_q  <= RES_OK;
            vec_q  <= VEC_NONE;
        end else begin
            done_q <= busy_q;
            if (busy_q) begin
                busy_q <= 1'b0;
                res_q  <= eval_res;
                vec_q  <= eval_vec;
            end else if (accept) begin
                busy_q <= 1'b1;
            end
        end
    end

    seg_load_eval #(
        .SEL_W (SEL_W),
        .LIM_W (LIM_W)
    ) u_eval (
        .seg    (cur_seg),
        .sel    (cur_sel),
        .limit  (cur_limit),
        .typ    (cur_typ),
        .s_bit  (cur_s),
        .p_bit  (cur_p),
        .res    (eval_res),
        .vec    (eval_vec),
        .usable (eval_usable)
    );

    seg_file #(
        .NUM_SEG (NUM_SEG),
        .SEL_W   (SEL_W),
        .IDX_W   (IDX_W)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit),
        .wr_idx    (cur_seg),
        .wr_sel    (cur_sel),
        .wr_typ    (cur_typ),
        .wr_s      (cur_s),
        .wr_p      (cur_p),
        .wr_usable (eval_usable),
        .rd_idx    (rd_seg),
        .rd_sel    (rd_sel),
        .rd_typ    (rd_type),
        .rd_s      (rd_s),
        .rd_p      (rd_p),
        .rd_usable (rd_usable)
    );

    assign busy    = busy_q;
    assign done    = done_q;
    assign outcome = res_q;
    assign vector  = vec_q;

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !busy_q) |=> busy_q); // R11
    AST_BUSY_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) busy_q |=> (done_q && !busy_q)); // R11
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R11
    AST_SS_WRITABLE_DATA: assert property (@(posedge clk) disable iff (!rst_n) (commit && (cur_seg == SEG_SS)) |-> (!cur_typ[TYP_CODE] && cur_typ[TYP_RW] && cur_s)); // R5
    AST_NP_NEEDS_ABSENT: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && (eval_res == RES_NP)) |-> !cur_p); // R7
    AST_UNUSABLE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n) (commit && !eval_usable) |-> (cur_seg >= 3'(SEG_DS))); // R2

endmodule

// File: tb/seg_load_check_tb.sv
`timescale 1ns/1ps
// Bench for the segment register load checker: a vector table walked by one
// loop, a reference copy of every register kept from the requirements, then
// directed checks of reset and of requests arriving while busy.
module seg_load_check_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [15:0] req_sel = '0;
    logic [15:0] req_limit = '0;
    logic [3:0]  req_type = '0;
    logic        req_s = 1'b0;
    logic        req_p = 1'b0;
    logic        busy;
    logic        done;
    logic [1:0]  outcome;
    logic [7:0]  vector;
    logic [2:0]  rd_seg = '0;
    logic [15:0] rd_sel;
    logic [3:0]  rd_type;
    logic        rd_s;
    logic        rd_p;
    logic        rd_usable;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [15:0] m_sel [6];
    logic [3:0]  m_typ [6];
    logic        m_s   [6];
    logic        m_p   [6];
    logic        m_use [6];

    always #2.5 clk = ~clk;

    seg_load_check u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_seg   (req_seg),
        .req_sel   (req_sel),
        .req_limit (req_limit),
        .req_type  (req_type),
        .req_s     (req_s),
        .req_p     (req_p),
        .busy      (busy),
        .done      (done),
        .outcome   (outcome),
        .vector    (vector),
        .rd_seg    (rd_seg),
        .rd_sel    (rd_sel),
        .rd_type   (rd_type),
        .rd_s      (rd_s),
        .rd_p      (rd_p),
        .rd_usable (rd_usable)
    );

    // Row: seg[54:52] sel[51:36] limit[35:20] type[19:16] s[15] p[14]
    //      outcome[13:12] vector[11:4] requirement[3:0]
    localparam int NV = 22;
    localparam logic [54:0] TBL [NV] = '{
        {3'd2, 16'h0010, 16'h0027, 4'b0010, 1'b1, 1'b1, 2'd0, 8'd0,  4'd6},
        {3'd0, 16'h0008, 16'h0027, 4'b1010, 1'b1, 1'b1, 2'd0, 8'd0,  4'd4},
        {3'd1, 16'h0018, 16'h0027, 4'b0110, 1'b1, 1'b1, 2'd0, 8'd0,  4'd5},
        {3'd1, 16'h0020, 16'h0027, 4'b0000, 1'b1, 1'b1, 2'd1, 8'd13, 4'd5},
        {3'd1, 16'h0020, 16'h0027, 4'b1010, 1'b1, 1'b1, 2'd1, 8'd13, 4'd5},
        {3'd0, 16'h0000, 16'h0027, 4'b1010, 1'b1, 1'b1, 2'd1, 8'd13, 4'd1},
        {3'd1, 16'h0003, 16'h0027, 4'b0010, 1'b1, 1'b1, 2'd1, 8'd13, 4'd1},
        {3'd3, 16'h0000, 16'h0027, 4'b0000, 1'b0, 1'b0, 2'd0, 8'd0,  4'd2},
        {3'd4, 16'h0028, 16'h0027, 4'b0010, 1'b1, 1'b1, 2'd1, 8'd13, 4'd3},
        {3'd4, 16'h0020, 16'h0026, 4'b0010, 1'b1, 1'b1, 2'd1, 8'd13, 4'd3},
        {3'd4, 16'h0020, 16'h0027, 4'b0010, 1'b1, 1'b1, 2'd0, 8'd0,  4'd3},
        {3'd5, 16'h0020, 16'h0027, 4'b1000, 1'b1, 1'b1, 2'd1, 8'd13, 4'd6},
        {3'd5, 16'h0020, 16'h0027, 4'b1010, 1'b1, 1'b1, 2'd0, 8'd0,  4'd6},
        {3'd2, 16'h0018, 16'h0027, 4'b0010, 1'b1, 1'b0, 2'd2, 8'd11, 4'd7},
        {3'd1, 16'h0018, 16'h0027, 4'b0010, 1'b1, 1'b0, 2'd2, 8'd12, 4'd7},
        {3'd0, 16'h0018, 16'h0027, 4'b0010, 1'b1, 1'b1, 2'd1, 8'd13, 4'd4},
        {3'd2, 16'h0018, 16'h0027, 4'b0010, 1'b0, 1'b1, 2'd1, 8'd13, 4'd4},
        {3'd2, 16'h0030, 16'h0027, 4'b0010, 1'b1, 1'b0, 2'd1, 8'd13, 4'd8},
        {3'd1, 16'h0018, 16'h0027, 4'b0000, 1'b1, 1'b0, 2'd1, 8'd13, 4'd8},
        {3'd0, 16'h0000, 16'h0000, 4'b1010, 1'b1, 1'b0, 2'd1, 8'd13, 4'd8},
        {3'd3, 16'h000B, 16'h0027, 4'b0011, 1'b1, 1'b1, 2'd0, 8'd0,  4'd10},
        {3'd3, 16'h0004, 16'h0000, 4'b0000, 1'b0, 1'b0, 2'd0, 8'd0,  4'd2}
    };

    function automatic string tag_name(input int n);
        case (n)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Compare the read port for one register against the reference copy.
    task automatic chk_reg(input string tag, input int idx);
        rd_seg = 3'(idx);
        #0.1;
        chk(tag, "rd_sel",    32'(rd_sel),    32'(m_sel[idx]));
        chk(tag, "rd_type",   32'(rd_type),   32'(m_typ[idx]));
        chk(tag, "rd_s",      32'(rd_s),      32'(m_s[idx]));
        chk(tag, "rd_p",      32'(rd_p),      32'(m_p[idx]));
        chk(tag, "rd_usable", 32'(rd_usable), 32'(m_use[idx]));
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    // Ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R11 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 6; k++) begin
            m_sel[k] = '0; m_typ[k] = '0; m_s[k] = 1'b0; m_p[k] = 1'b0; m_use[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state at the ports
        chk("R12", "busy", 32'(busy), 32'd0);
        chk("R12", "done", 32'(done), 32'd0);
        for (int k = 0; k < 6; k++) chk_reg("R12", k);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [54:0] e;
            int          sg;
            string       tg;
            e  = TBL[i];
            sg = int'(e[54:52]);
            tg = tag_name(int'(e[3:0]));
            @(negedge clk);
            req_seg   = e[54:52];
            req_sel   = e[51:36];
            req_limit = e[35:20];
            req_type  = e[19:16];
            req_s     = e[15];
            req_p     = e[14];
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R11", "busy", 32'(busy), 32'd1);
            chk("R11", "done early", 32'(done), 32'd0);
            @(negedge clk);
            chk("R11", "done", 32'(done), 32'd1);
            chk(tg, "outcome", 32'(outcome), 32'(e[13:12]));
            chk(tg, "vector",  32'(vector),  32'(e[11:4]));
            if (e[13:12] == 2'd0) begin
                m_sel[sg] = e[51:36];
                if (e[51:39] == '0) begin
                    m_typ[sg] = '0; m_s[sg] = 1'b0; m_p[sg] = 1'b0; m_use[sg] = 1'b0;
                end else begin
                    m_typ[sg] = e[19:16] | 4'b0001;
                    m_s[sg] = e[15]; m_p[sg] = e[14]; m_use[sg] = 1'b1;
                end
                chk_reg(tg, sg);
            end else begin
                chk_reg("R9", sg);
            end
            @(negedge clk);
            chk("R11", "done pulse end", 32'(done), 32'd0);
        end

        // R11: a request held while busy is ignored
        @(negedge clk);
        req_seg = 3'd2; req_sel = 16'h0008; req_limit = 16'h0027;
        req_type = 4'b0010; req_s = 1'b1; req_p = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        chk("R11", "busy held", 32'(busy), 32'd1);
        req_seg = 3'd4; req_sel = 16'h0010;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "done held", 32'(done), 32'd1);
        chk("R11", "outcome held", 32'(outcome), 32'd0);
        m_sel[2] = 16'h0008; m_typ[2] = 4'b0011; m_s[2] = 1'b1; m_p[2] = 1'b1; m_use[2] = 1'b1;
        chk_reg("R11", 2);
        @(negedge clk);
        chk("R11", "no second done", 32'(done), 32'd0);
        chk("R11", "idle", 32'(busy), 32'd0);
        chk_reg("R11", 4);

        // R12: reset clears committed state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            m_sel[k] = '0; m_typ[k] = '0; m_s[k] = 1'b0; m_p[k] = 1'b0; m_use[k] = 1'b0;
        end
        @(negedge clk);
        chk("R12", "busy after reset", 32'(busy), 32'd0);
        for (int k = 0; k < 6; k++) chk_reg("R12", k);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule